// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between a 32-bit integer core and a byte-addressed data memory that is one word wide. When the core issues an access, the block forms the effective address from a base register value and a signed 16-bit displacement. For stores, it raises the byte-lane write strobes and places the store value into the enabled lanes. For loads, it records the access width, the signedness and the byte offset. It uses these to pick the addressed byte or halfword out of the word that the memory returns, and it extends that value to the full 32 bits.

Lanes are numbered big-endian. Byte offset 0 of a word is its most significant byte, bits 31:24, and strobe bit 3 belongs to offset 0. An access whose address is not a multiple of its size is flagged as misaligned and never reaches memory. The memory is synchronous, so read data arrives in the cycle after the read strobe. An optional output stage adds one more cycle of load latency.

The operation code is four bits wide:
- Bit 3 selects a store (1) or a load (0).
- Bit 2 selects zero extension.
- Bits 1:0 give the size: 00 byte, 01 halfword, 10 word.

The legal codes are:

| Instruction | Code |
|---|---|
| lb | 0000 |
| lh | 0001 |
| lw | 0010 |
| lbu | 0100 |
| lhu | 0101 |
| sb | 1000 |
| sh | 1001 |
| sw | 1010 |

Top module: `lsu_be_aligner`

## Requirements
- R1: `mem_addr` equals `req_base` plus `req_disp` sign-extended to 32 bits, modulo 2^32.
- R2: Only the eight legal codes listed above are acted on. Any other code with `req_valid` high produces no read, no write strobes, no misalignment flag and no later `load_valid`.
- R3: Store strobes are big-endian, with strobe bit 3 for offset 0. A word store gives 1111. A halfword store gives 1100 at offset 0 and 0011 at offset 2. A byte store at offset k sets only bit 3-k.
- R4: Store data is replicated across lanes. A byte store drives its low byte into all four lanes. A halfword store drives its low halfword into both halves. A word store drives the word unchanged.
- R5: A halfword at an odd address, or a word whose address bits 1:0 are not 00, raises `misalign`. That access makes no memory read and no memory write. Byte accesses are never misaligned.
- R6: With the default latency, `load_valid` is high in exactly the cycle after a cycle in which `mem_ren` was high. `load_data` is then formed from `mem_rdata` in that cycle.
- R7: A byte load at offset k takes bits 31-8k down to 24-8k of the returned word. Code lb sign-extends it and code lbu zero-extends it.
- R8: A halfword load takes bits 31:16 at offset 0 and bits 15:0 at offset 2. Code lh sign-extends it and code lhu zero-extends it.
- R9: A word load returns all 32 bits unchanged. Whenever `load_valid` is low, `load_data` is zero.
- R10: While `rst_n` is low, `load_valid` is low and `load_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_op | input | 4 | Operation code |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | 32 | Effective byte address |
| mem_ren | output | 1 | Memory read strobe |
| mem_wen | output | 4 | Byte-lane write strobes, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Word returned by memory one cycle after `mem_ren` |
| misalign | output | 1 | Misaligned access flag |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Aligned and extended load result |

## Verification
Several properties are checked on every cycle:
- the shape of the strobe pattern;
- that misaligned and illegal requests never reach memory;
- that a byte store carries the same byte in every lane;
- that the result valid follows each read with the configured latency;
- that the result is zero while no result is valid.

The big-endian lane numbering, the exact strobe pattern for each offset, sign versus zero extension, and the address sum with negative displacements depend on particular data values. Only the directed scenarios, with expected words worked out by hand, show these.

// File: rtl/lsu_be_pkg.sv
package lsu_be_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_NONE = 2'b11
   } acc_size_e;

   typedef struct packed {
      logic      is_store;
      logic      is_unsigned;
      acc_size_e size;
   } lsu_op_t;

   typedef struct packed {
      logic       is_unsigned;
      acc_size_e  size;
      logic [1:0] ofs;
   } ld_ctx_t;

   function automatic logic op_legal(input lsu_op_t o);
      logic ok;
      ok = (o.size != SZ_NONE);
      if (o.is_store && o.is_unsigned) ok = 1'b0;
      if (o.is_unsigned && o.size == SZ_WORD) ok = 1'b0;
      return ok;
   endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
   import lsu_be_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int DISP_W = 16
) (
   input  logic [XLEN-1:0]   base,
   input  logic [DISP_W-1:0] disp,
   input  acc_size_e         size,
   output logic [XLEN-1:0]   ea,
   output logic              misaligned
);
   localparam int EXT_W = XLEN - DISP_W;

   logic [XLEN-1:0] disp_x;

   generate
      if (EXT_W > 0) begin : g_sext
         assign disp_x = {{EXT_W{disp[DISP_W-1]}}, disp};
      end else begin : g_trunc
         assign disp_x = disp[XLEN-1:0];
      end
   endgenerate

   assign ea = base + disp_x;

   always_comb begin
      unique case (size)
         SZ_HALF: misaligned = ea[0];
         SZ_WORD: misaligned = |ea[1:0];
         default: misaligned = 1'b0;
      endcase
   end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_be_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  acc_size_e          size,
   input  logic [1:0]         ofs,
   input  logic [XLEN-1:0]    src,
   output logic [XLEN/8-1:0]  be,
   output logic [XLEN-1:0]    lanes
);
   localparam int NL = XLEN / 8;

   generate
      for (genvar i = 0; i < NL; i++) begin : g_lane
         localparam int         LANE_OFS = NL - 1 - i;
         localparam logic [1:0] OFS_B    = LANE_OFS[1:0];
         always_comb begin
            unique case (size)
               SZ_BYTE: begin
                  be[i]          = (ofs == OFS_B);
                  lanes[8*i +: 8] = src[7:0];
               end
               SZ_HALF: begin
                  be[i]          = (ofs[1] == OFS_B[1]);
                  lanes[8*i +: 8] = OFS_B[0] ? src[7:0] : src[15:8];
               end
               SZ_WORD: begin
                  be[i]          = 1'b1;
                  lanes[8*i +: 8] = src[8*i +: 8];
               end
               default: begin
                  be[i]          = 1'b0;
                  lanes[8*i +: 8] = 8'h00;
               end
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_be_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  ld_ctx_t          ctx,
   input  logic [XLEN-1:0]  rdata,
   output logic [XLEN-1:0]  result
);
   localparam int NL = XLEN / 8;

   logic [7:0]  lane_b [NL];
   logic [7:0]  bsel;
   logic [15:0] hsel;

   generate
      for (genvar k = 0; k < NL; k++) begin : g_pick
         assign lane_b[k] = rdata[8*(NL-1-k) +: 8];
      end
   endgenerate

   assign bsel = lane_b[ctx.ofs];
   assign hsel = ctx.ofs[1] ? rdata[15:0] : rdata[31:16];

   always_comb begin
      unique case (ctx.size)
         SZ_BYTE: result = ctx.is_unsigned ? {{(XLEN-8){1'b0}}, bsel}
                                           : {{(XLEN-8){bsel[7]}}, bsel};
         SZ_HALF: result = ctx.is_unsigned ? {{(XLEN-16){1'b0}}, hsel}
                                           : {{(XLEN-16){hsel[15]}}, hsel};
         SZ_WORD: result = rdata;
         default: result = '0;
      endcase
   end
endmodule

// File: rtl/lsu_be_aligner.sv
module lsu_be_aligner
   import lsu_be_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int DISP_W    = 16,
   parameter int LOAD_PIPE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [3:0]        req_op,
   input  logic [XLEN-1:0]   req_base,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [XLEN-1:0]   req_wdata,
   output logic [XLEN-1:0]   mem_addr,
   output logic              mem_ren,
   output logic [XLEN/8-1:0] mem_wen,
   output logic [XLEN-1:0]   mem_wdata,
   input  logic [XLEN-1:0]   mem_rdata,
   output logic              misalign,
   output logic              load_valid,
   output logic [XLEN-1:0]   load_data
);
   localparam int NL = XLEN / 8;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("lsu_be_aligner: XLEN must be 32");
      end
      if (DISP_W < 2 || DISP_W > XLEN) begin : g_bad_disp
         $error("lsu_be_aligner: DISP_W out of range");
      end
      if (LOAD_PIPE != 0 && LOAD_PIPE != 1) begin : g_bad_pipe
         $error("lsu_be_aligner: LOAD_PIPE must be 0 or 1");
      end
   endgenerate

   lsu_op_t         op;
   logic            legal;
   logic            raw_mis;
   logic            go;
   logic [NL-1:0]   be_raw;
   ld_ctx_t         ctx_q;
   logic            pend_q;
   logic [XLEN-1:0] ext_data;

   assign op    = lsu_op_t'(req_op);
   assign legal = op_legal(op);

   lsu_addr_gen #(.XLEN(XLEN), .DISP_W(DISP_W)) u_agen (
      .base       (req_base),
      .disp       (req_disp),
      .size       (op.size),
      .ea         (mem_addr),
      .misaligned (raw_mis)
   );

   lsu_store_lanes #(.XLEN(XLEN)) u_slane (
      .size  (op.size),
      .ofs   (mem_addr[1:0]),
      .src   (req_wdata),
      .be    (be_raw),
      .lanes (mem_wdata)
   );

   assign go       = req_valid && legal && !raw_mis;
   assign misalign = req_valid && legal && raw_mis;
   assign mem_ren  = go && !op.is_store;
   assign mem_wen  = (go && op.is_store) ? be_raw : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         ctx_q  <= '0;
      end else begin
         pend_q <= mem_ren;
         if (mem_ren) begin
            ctx_q.is_unsigned <= op.is_unsigned;
            ctx_q.size        <= op.size;
            ctx_q.ofs         <= mem_addr[1:0];
         end
      end
   end

   lsu_load_extract #(.XLEN(XLEN)) u_lext (
      .ctx    (ctx_q),
      .rdata  (mem_rdata),
      .result (ext_data)
   );

   generate
      if (LOAD_PIPE == 1) begin : g_pipe
         logic            v_q;
         logic [XLEN-1:0] d_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= '0;
            end else begin
               v_q <= pend_q;
               d_q <= pend_q ? ext_data : '0;
            end
         end
         assign load_valid = v_q;
         assign load_data  = d_q;
      end else begin : g_direct
         assign load_valid = pend_q;
         assign load_data  = pend_q ? ext_data : '0;
      end
   endgenerate
endmodule

// File: rtl/lsu_be_aligner_chk.sv
module lsu_be_aligner_chk
   import lsu_be_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int LOAD_PIPE = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [3:0]        req_op,
   input logic              mem_ren,
   input logic [XLEN/8-1:0] mem_wen,
   input logic [XLEN-1:0]   mem_wdata,
   input logic              misalign,
   input logic              load_valid,
   input logic [XLEN-1:0]   load_data
);
   logic [1:0] ren_hist;
   logic       exp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) ren_hist <= 2'b00;
      else        ren_hist <= {ren_hist[0], mem_ren};
   end

   assign exp_valid = (LOAD_PIPE == 1) ? ren_hist[1] : ren_hist[0];

   // R3: strobe pattern is empty, one lane, a half pair or all lanes
   a_r3_strobe_shape: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(mem_wen) != 3) && !(mem_wen == 4'b0110) && !(mem_wen == 4'b1001)
      && !(mem_wen == 4'b0101) && !(mem_wen == 4'b1010));

   // R4: a single-lane write carries the same byte in every lane
   a_r4_byte_replicated: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(mem_wen) == 1) |->
         (mem_wdata[31:24] == mem_wdata[7:0]) && (mem_wdata[23:16] == mem_wdata[7:0])
         && (mem_wdata[15:8] == mem_wdata[7:0]));

   // R5: a misaligned access never reaches memory
   a_r5_no_access_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (mem_wen == '0) && !mem_ren);

   // R2: an illegal code does nothing
   a_r2_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !op_legal(lsu_op_t'(req_op))) |-> (mem_wen == '0) && !mem_ren && !misalign);

   // R6: result valid follows each read by the configured latency
   a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid == exp_valid);

   // R9: result is zero whenever it is not valid
   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !load_valid |-> (load_data == '0));

   // R2: reads and writes never occur together
   a_r2_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ren |-> (mem_wen == '0));
endmodule

bind lsu_be_aligner lsu_be_aligner_chk #(.XLEN(XLEN), .LOAD_PIPE(LOAD_PIPE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .mem_ren    (mem_ren),
   .mem_wen    (mem_wen),
   .mem_wdata  (mem_wdata),
   .misalign   (misalign),
   .load_valid (load_valid),
   .load_data  (load_data)
);

// File: tb/lsu_be_aligner_test.sv
module lsu_be_aligner_test;
   localparam logic [3:0] OP_LB  = 4'b0000, OP_LH  = 4'b0001, OP_LW = 4'b0010;
   localparam logic [3:0] OP_LBU = 4'b0100, OP_LHU = 4'b0101;
   localparam logic [3:0] OP_SB  = 4'b1000, OP_SH  = 4'b1001, OP_SW = 4'b1010;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [3:0]  req_op;
   logic [31:0] req_base;
   logic [15:0] req_disp;
   logic [31:0] req_wdata;
   logic [31:0] mem_addr;
   logic        mem_ren;
   logic [3:0]  mem_wen;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        misalign;
   logic        load_valid;
   logic [31:0] load_data;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   lsu_be_aligner uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_base(req_base), .req_disp(req_disp), .req_wdata(req_wdata),
      .mem_addr(mem_addr), .mem_ren(mem_ren), .mem_wen(mem_wen),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .misalign(misalign),
      .load_valid(load_valid), .load_data(load_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] op, input logic [31:0] base,
                        input logic [15:0] disp, input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_base = base; req_disp = disp; req_wdata = wd;
      #5;
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_addr(input logic [31:0] base, input logic [15:0] disp, input logic [31:0] exp);
      issue(OP_SB, base, disp, 32'h0);
      chk("R1 mem_addr", mem_addr, exp);
      idle();
   endtask

   task automatic t_store(input string req, input logic [3:0] op, input logic [31:0] addr,
                          input logic [31:0] wd, input logic [3:0] exp_wen,
                          input logic [31:0] exp_wd, input logic exp_mis);
      issue(op, addr, 16'h0000, wd);
      chk({req, " mem_wen"}, {28'h0, mem_wen}, {28'h0, exp_wen});
      if (!exp_mis) chk({req, " mem_wdata"}, mem_wdata, exp_wd);
      chk({req, " misalign"}, {31'h0, misalign}, {31'h0, exp_mis});
      chk({req, " no read on store"}, {31'h0, mem_ren}, 32'h0);
      idle();
   endtask

   task automatic t_load(input string req, input logic [3:0] op, input logic [31:0] addr,
                         input logic [31:0] rd, input logic [31:0] exp);
      issue(op, addr, 16'h0000, 32'h0);
      chk("R6 mem_ren", {31'h0, mem_ren}, 32'h1);
      chk("R6 no write on load", {28'h0, mem_wen}, 32'h0);
      @(negedge clk);
      req_valid = 1'b0; mem_rdata = rd;
      #5;
      chk("R6 load_valid", {31'h0, load_valid}, 32'h1);
      chk({req, " load_data"}, load_data, exp);
      @(negedge clk);
      #5;
      chk("R6 load_valid drops", {31'h0, load_valid}, 32'h0);
      chk("R9 idle data zero", load_data, 32'h0);
   endtask

   task automatic t_noaccess(input string req, input logic [3:0] op, input logic [31:0] addr,
                             input logic exp_mis);
      issue(op, addr, 16'h0000, 32'hFFFF_FFFF);
      chk({req, " mem_ren"}, {31'h0, mem_ren}, 32'h0);
      chk({req, " mem_wen"}, {28'h0, mem_wen}, 32'h0);
      chk({req, " misalign"}, {31'h0, misalign}, {31'h0, exp_mis});
      @(negedge clk);
      req_valid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      #5;
      chk({req, " no load_valid"}, {31'h0, load_valid}, 32'h0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_op = 4'h0; req_base = 32'h0;
      req_disp = 16'h0; req_wdata = 32'h0; mem_rdata = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      #5;
      chk("R10 reset load_valid", {31'h0, load_valid}, 32'h0);
      chk("R10 reset load_data", load_data, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 address generation
      t_addr(32'h0000_1000, 16'hFFFC, 32'h0000_0FFC);
      t_addr(32'h0000_0010, 16'h7FFF, 32'h0000_800F);
      t_addr(32'h0000_0000, 16'h8000, 32'hFFFF_8000);

      // R3 R4 stores
      t_store("R3 sw", OP_SW, 32'h1000, 32'hA1B2C3D4, 4'b1111, 32'hA1B2C3D4, 1'b0);
      t_store("R3 sh ofs0", OP_SH, 32'h1000, 32'hA1B2C3D4, 4'b1100, 32'hC3D4C3D4, 1'b0);
      t_store("R4 sh ofs2", OP_SH, 32'h1002, 32'hA1B2C3D4, 4'b0011, 32'hC3D4C3D4, 1'b0);
      t_store("R3 sb ofs0", OP_SB, 32'h1000, 32'hA1B2C3D4, 4'b1000, 32'hD4D4D4D4, 1'b0);
      t_store("R3 sb ofs1", OP_SB, 32'h1001, 32'hA1B2C3D4, 4'b0100, 32'hD4D4D4D4, 1'b0);
      t_store("R4 sb ofs2", OP_SB, 32'h1002, 32'hA1B2C3D4, 4'b0010, 32'hD4D4D4D4, 1'b0);
      t_store("R3 sb ofs3", OP_SB, 32'h1003, 32'hA1B2C3D4, 4'b0001, 32'hD4D4D4D4, 1'b0);

      // R5 misaligned stores
      t_store("R5 sw ofs1", OP_SW, 32'h1001, 32'hA1B2C3D4, 4'b0000, 32'h0, 1'b1);
      t_store("R5 sw ofs2", OP_SW, 32'h1002, 32'hA1B2C3D4, 4'b0000, 32'h0, 1'b1);
      t_store("R5 sh ofs3", OP_SH, 32'h1003, 32'hA1B2C3D4, 4'b0000, 32'h0, 1'b1);

      // R7 byte loads
      t_load("R7 lb ofs0", OP_LB,  32'h2000, 32'h80F17F02, 32'hFFFFFF80);
      t_load("R7 lbu ofs0", OP_LBU, 32'h2000, 32'h80F17F02, 32'h00000080);
      t_load("R7 lb ofs1", OP_LB,  32'h2001, 32'h80F17F02, 32'hFFFFFFF1);
      t_load("R7 lb ofs2", OP_LB,  32'h2002, 32'h80F17F02, 32'h0000007F);
      t_load("R7 lbu ofs3", OP_LBU, 32'h2003, 32'h80F17F02, 32'h00000002);

      // R8 halfword loads
      t_load("R8 lh ofs0", OP_LH,  32'h2000, 32'h80F17F02, 32'hFFFF80F1);
      t_load("R8 lhu ofs0", OP_LHU, 32'h2000, 32'h80F17F02, 32'h000080F1);
      t_load("R8 lh ofs2", OP_LH,  32'h2002, 32'h80F17F02, 32'h00007F02);
      t_load("R8 lh ofs2 neg", OP_LH, 32'h2002, 32'h12348001, 32'hFFFF8001);
      t_load("R8 lhu ofs2", OP_LHU, 32'h2002, 32'h12348001, 32'h00008001);

      // R9 word load
      t_load("R9 lw", OP_LW, 32'h2004, 32'h80F17F02, 32'h80F17F02);

      // R5 misaligned loads
      t_noaccess("R5 lw ofs3", OP_LW, 32'h2003, 1'b1);
      t_noaccess("R5 lhu ofs1", OP_LHU, 32'h2001, 1'b1);

      // R2 illegal codes
      t_noaccess("R2 code 0011", 4'b0011, 32'h2000, 1'b0);
      t_noaccess("R2 code 1100", 4'b1100, 32'h2000, 1'b0);
      t_noaccess("R2 code 0110", 4'b0110, 32'h2000, 1'b0);
      t_noaccess("R2 code 1011", 4'b1011, 32'h2000, 1'b0);
      idle();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule